// File: doc/BRIEF.md
# Serial Address/Data Adapter for a Parallel PROM

This block sits beside a parallel PROM and connects it to a processor over a narrow serial link. The processor shifts a PROM address in one bit per serial-clock enable. A one-cycle load strobe then does two things at once. It copies the collected address onto the PROM address pins, and it parallel-loads the PROM's 16-bit output word into the same shift register. During the next window, that word shifts back toward the processor while the next address shifts in.

One shift register carries both directions. Bits enter at the least significant end and leave from the most significant end. Because of this, each fetch is pipelined across two strobes. The data returned in a window belongs to the address that was presented two strobes earlier.

Top module: `serial_prom_adapter`

## Requirements
- R1: An active-low synchronous reset clears the shift register and the address register, so `prom_addr` reads 0 and `ser_out` reads 0.
- R2: When `sclk_en` is low, no state changes, whatever `ser_in` and `load_stb` do.
- R3: With `sclk_en` high and `load_stb` low, the shift register moves one place toward its top bit and takes `ser_in` into bit 0. `ser_out` always shows bit 21, the top bit.
- R4: With `sclk_en` and `load_stb` both high, `prom_addr` takes the low 21 bits of the shift register. The last bit shifted in becomes address bit 0.
- R5: On that same strobe, the shift register loads `prom_data` into bits 21:6 and zeros into bits 5:0. The word then leaves on `ser_out` with its most significant bit first, followed by six zeros.
- R6: `prom_addr` holds its value through a whole shift window and changes only on a strobe.
- R7: `ser_in` is ignored on a strobe cycle. The six low bits after a load are zero even when `ser_in` is 1.
- R8: Shifting 22 bits out and 22 bits in happens in the same window. After the window, the outgoing word has left completely and the register holds the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk_en | input | 1 | Serial-clock enable; all state moves only when it is high |
| load_stb | input | 1 | One-cycle strobe that swaps the address out and the data in |
| ser_in | input | 1 | Serial address bit from the processor |
| ser_out | output | 1 | Serial data bit toward the processor (shift register top bit) |
| prom_addr | output | 21 | Address presented to the PROM |
| prom_data | input | 16 | Parallel data word from the PROM |

## Verification
The main flow is driven with a table of 22-bit shift words whose patterns differ: all ones, all zeros, alternating bits, walking values, and a word whose extra top bit is set. Each word is followed by a strobe. The address that appears after each strobe shows whether the low 21 bits land in the correct order and whether the extra bit is dropped. The serial word captured in the following window shows that data and padding are placed correctly, and that the two-strobe pipeline delay is right. Directed cases cover the following:
- Strobes and serial toggles while the enable is low.
- A strobe with the serial input held high.
- Address stability across a window.
- A reset in the middle of operation.

// File: rtl/spa_pkg.sv
// Package: shared operation type and decoder for the serial PROM adapter.
// Assumes the load strobe has meaning only while the serial-clock enable is high.
package spa_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_SWAP  = 2'd2
    } spa_op_t;

    // Map the enable and strobe onto one operation.
    function automatic spa_op_t spa_decode(input logic en, input logic stb);
        if (!en)
            return OP_IDLE;
        else if (stb)
            return OP_SWAP;
        else
            return OP_SHIFT;
    endfunction

endpackage

// File: rtl/spa_shifter.sv
// Shared shift register. It takes address bits at bit 0, sends data from the
// top bit, and parallel-loads the data word into the top bits on a swap.
// Assumes SHIFT_W >= DATA_W; the bits below the data load as zero.
module spa_shifter
    import spa_pkg::*;
#(
    parameter int SHIFT_W = 22,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  spa_op_t            op,
    input  logic               ser_in,
    input  logic [DATA_W-1:0]  par_in,
    output logic [SHIFT_W-1:0] shreg
);
    localparam int PAD_W = SHIFT_W - DATA_W;

    logic [SHIFT_W-1:0] load_word;

    // Place the data word at the outgoing end, with zero padding below it.
    generate
        if (PAD_W > 0) begin : g_pad
            assign load_word = {par_in, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign load_word = par_in[DATA_W-1 -: SHIFT_W];
        end
    endgenerate

    // Register update: hold, shift one place, or parallel load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else begin
            case (op)
                OP_SHIFT: shreg <= {shreg[SHIFT_W-2:0], ser_in};
                OP_SWAP:  shreg <= load_word;
                default:  shreg <= shreg;
            endcase
        end
    end

endmodule

// File: rtl/spa_present.sv
// Presentation register. It drives the PROM address pins, captures the low
// ADDR_W bits of the shift register on a swap, and holds them otherwise.
// Assumes ADDR_W < SHIFT_W.
module spa_present
    import spa_pkg::*;
#(
    parameter int SHIFT_W = 22,
    parameter int ADDR_W  = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  spa_op_t            op,
    input  logic [SHIFT_W-1:0] shreg,
    output logic [ADDR_W-1:0]  addr_q
);
    // Capture the address on a swap only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (op == OP_SWAP)
            addr_q <= shreg[ADDR_W-1:0];
    end

endmodule

// File: rtl/serial_prom_adapter.sv
// Top level. It joins the operation decoder, the shared shift register and
// the presentation register. Assumes the caller produces exactly one strobe
// cycle per window.
module serial_prom_adapter
    import spa_pkg::*;
#(
    parameter int ADDR_W  = 21,
    parameter int DATA_W  = 16,
    parameter int SHIFT_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_en,
    input  logic              load_stb,
    input  logic              ser_in,
    output logic              ser_out,
    output logic [ADDR_W-1:0] prom_addr,
    input  logic [DATA_W-1:0] prom_data
);
    spa_op_t            op;
    logic [SHIFT_W-1:0] shreg_q;

    // Decode the operation once and share it between both registers.
    always_comb op = spa_decode(sclk_en, load_stb);

    spa_shifter #(.SHIFT_W(SHIFT_W), .DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .op(op), .ser_in(ser_in),
        .par_in(prom_data), .shreg(shreg_q)
    );

    spa_present #(.SHIFT_W(SHIFT_W), .ADDR_W(ADDR_W)) u_pres (
        .clk(clk), .rst_n(rst_n), .op(op), .shreg(shreg_q), .addr_q(prom_addr)
    );

    // The serial output is the top bit of the shift register.
    assign ser_out = shreg_q[SHIFT_W-1];

endmodule

// File: rtl/serial_prom_adapter_chk.sv
// Checker for serial_prom_adapter. It watches the ports and the shift
// register, and is attached to the top module by the bind below.
module serial_prom_adapter_chk #(
    parameter int ADDR_W  = 21,
    parameter int DATA_W  = 16,
    parameter int SHIFT_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk_en,
    input logic              load_stb,
    input logic              ser_out,
    input logic [ADDR_W-1:0] prom_addr,
    input logic [DATA_W-1:0] prom_data,
    input logic [SHIFT_W-1:0] shreg_q
);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_en |=> ($stable(prom_addr) && $stable(ser_out)));

    p_shift_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_en && !load_stb) |=> (ser_out == $past(shreg_q[SHIFT_W-2])));

    p_addr_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_en && load_stb) |=> (prom_addr == $past(shreg_q[ADDR_W-1:0])));

    p_data_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_en && load_stb) |=> (ser_out == $past(prom_data[DATA_W-1])));

    p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_en && load_stb) |=> $stable(prom_addr));

    p_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_en && load_stb) |=> (shreg_q[SHIFT_W-DATA_W-1:0] == '0));

endmodule

bind serial_prom_adapter serial_prom_adapter_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHIFT_W(SHIFT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .load_stb(load_stb),
    .ser_out(ser_out), .prom_addr(prom_addr), .prom_data(prom_data),
    .shreg_q(shreg_q)
);

// File: tb/serial_prom_adapter_bench.sv
module serial_prom_adapter_bench;
    localparam int AW = 21;
    localparam int DW = 16;
    localparam int SW = 22;
    localparam int NV = 6;
    localparam logic [SW-1:0] VEC [NV] = '{
        22'h1FFFFF, 22'h000000, 22'h155555, 22'h2AAAAA, 22'h012345, 22'h3C0F0F
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk_en = 1'b0;
    logic          load_stb = 1'b0;
    logic          ser_in = 1'b0;
    logic          ser_out;
    logic [AW-1:0] prom_addr;
    logic [DW-1:0] prom_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [AW-1:0] pres_m = '0;
    logic [SW-1:0] exp_out = '0;

    always #10 clk = ~clk;

    // PROM content model, computed from the address.
    function automatic logic [DW-1:0] rom(input logic [AW-1:0] a);
        return a[15:0] ^ {a[20:16], 11'h2B5} ^ 16'hC3A1;
    endfunction
    assign prom_data = rom(prom_addr);

    serial_prom_adapter u_serial_prom_adapter (
        .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .load_stb(load_stb),
        .ser_in(ser_in), .ser_out(ser_out), .prom_addr(prom_addr),
        .prom_data(prom_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Shift a word in, capturing ser_out; also count address changes (R6).
    task automatic shift_word(input logic [SW-1:0] w, output logic [SW-1:0] got,
                              output int addr_moves);
        logic [AW-1:0] a0;
        got = '0;
        addr_moves = 0;
        a0 = prom_addr;
        for (int i = SW - 1; i >= 0; i--) begin
            @(negedge clk);
            got = {got[SW-2:0], ser_out};
            if (prom_addr !== a0) addr_moves++;
            sclk_en = 1'b1; load_stb = 1'b0; ser_in = w[i];
        end
        @(negedge clk);
        sclk_en = 1'b0;
    endtask

    // One strobe cycle; ser_in is driven to the given level.
    task automatic strobe(input logic sin);
        @(negedge clk);
        sclk_en = 1'b1; load_stb = 1'b1; ser_in = sin;
        exp_out = {rom(pres_m), 6'b0};
        @(negedge clk);
        sclk_en = 1'b0; load_stb = 1'b0; ser_in = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [SW-1:0] got;
        int moves;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(prom_addr == '0, "R1 addr", 32'(prom_addr), 0);
        chk(ser_out == 1'b0, "R1 ser_out", 32'(ser_out), 0);
        rst_n = 1'b1;

        // Table walk: R3, R4, R5, R8
        for (int k = 0; k < NV; k++) begin
            shift_word(VEC[k], got, moves);
            chk(got == exp_out, "R5/R8 returned word", 32'(got), 32'(exp_out));
            chk(moves == 0, "R6 addr stable in window", 32'(moves), 0);
            strobe(1'b0);
            pres_m = VEC[k][AW-1:0];
            chk(prom_addr == pres_m, "R3/R4 captured addr", 32'(prom_addr), 32'(pres_m));
        end

        // R2: enable low ignores strobe and serial input
        shift_word(22'h0ABCDE, got, moves);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            sclk_en = 1'b0; load_stb = 1'b1; ser_in = i[0];
        end
        @(negedge clk);
        load_stb = 1'b0;
        chk(prom_addr == pres_m, "R2 addr held", 32'(prom_addr), 32'(pres_m));
        chk(ser_out == 1'b0, "R2 ser_out held", 32'(ser_out), 0);
        // R7: strobe with ser_in high
        strobe(1'b1);
        pres_m = 21'h0ABCDE;
        chk(prom_addr == pres_m, "R2 shreg untouched", 32'(prom_addr), 32'(pres_m));
        shift_word(22'h000001, got, moves);
        chk(got[5:0] == 6'b0, "R7 pad zero", 32'(got[5:0]), 0);
        chk(got == exp_out, "R5 data after idle", 32'(got), 32'(exp_out));

        // R1: mid-run reset
        strobe(1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(prom_addr == '0, "R1 mid-run addr", 32'(prom_addr), 0);
        chk(ser_out == 1'b0, "R1 mid-run ser_out", 32'(ser_out), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule